// File: doc/BRIEF.md
# Floating-Point Two-Slot Issue Steering

This block sits at the issue stage of a floating-point unit. Each cycle it sees up to two floating-point operations, in program order, held in slot 0 (older) and slot 1 (younger). It decides which of them issue and steers each granted operation to one of two unequal execution pipes: the add pipe or the multiply pipe. For each slot it also reports the result latency, so a downstream scoreboard can tell when the result will be ready.

Divides enter through the add pipe, which they hold for only their issue cycle. The divider itself is not pipelined. It stays busy for the remaining cycles of the divide, and the block counts these down itself. Any divide that meets a busy divider is refused and flagged on a stall output. Non-divide work keeps flowing while the divider is busy.

All outputs are combinational from the slot inputs and the registered divider state.

Top module: `fpdi_top`

## Requirements
- R1: Class codes are 3 bits: 0 add, 1 conditional move, 2 branch, 3 multiply, 4 copy-sign, 5 divide; 6 and 7 are reserved. Pipe code 0 is the add pipe and 1 is the multiply pipe. The latency output is the cycle count in binary. An add or conditional move issues only to the add pipe, with latency 4.
- R2: A branch issues only to the add pipe, with latency 1.
- R3: A multiply issues only to the multiply pipe, with latency 4.
- R4: A copy-sign has latency 4 and may use either pipe. Alone, or next to another copy in slot 1, slot 0 takes the add pipe. Otherwise a copy takes the pipe the other slot's operation does not need.
- R5: Two operations issue in the same cycle only if they go to different pipes. Slot 1 is granted only when slot 0 is granted in the same cycle.
- R6: A divide with precision bit 0 (single) issues to the add pipe with latency 15. No other divide is granted in the 14 cycles after it. A divide presented 15 cycles after it issues.
- R7: A divide with precision bit 1 (double) issues to the add pipe with latency 22. No other divide is granted in the 21 cycles after it. A divide presented 22 cycles after it issues.
- R8: A divide that would otherwise be eligible but meets a busy divider is not granted, and the stall output is high in that cycle. Non-divide operations in the same cycles issue as usual, and the stall stays low for them.
- R9: A slot holding a reserved class code (6 or 7) is never granted and raises no stall. Slot 1 therefore cannot issue behind such a slot 0.
- R10: Synchronous active-low reset frees the divider, so a divide presented right after reset issues even if a divide was in progress before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s0_vld | input | 1 | Slot 0 (older) holds an operation |
| s0_cls | input | 3 | Slot 0 class code |
| s0_dbl | input | 1 | Slot 0 precision (1 = double) |
| s1_vld | input | 1 | Slot 1 (younger) holds an operation |
| s1_cls | input | 3 | Slot 1 class code |
| s1_dbl | input | 1 | Slot 1 precision (1 = double) |
| s0_go | output | 1 | Slot 0 issues this cycle |
| s0_pipe | output | 1 | Slot 0 pipe (0 add, 1 multiply) |
| s0_lat | output | LAT_W (5) | Slot 0 result latency in cycles |
| s1_go | output | 1 | Slot 1 issues this cycle |
| s1_pipe | output | 1 | Slot 1 pipe (0 add, 1 multiply) |
| s1_lat | output | LAT_W (5) | Slot 1 result latency in cycles |
| div_stall | output | 1 | An eligible divide is refused because the divider is busy |

## Verification
Grants, pipe choices, latencies and the stall all follow from the current inputs in the same cycle. The bench therefore drives each pattern just after a falling edge and samples the outputs one nanosecond later, well before the next rising edge. The divider state changes only at a rising edge: a divide granted in cycle N makes the next cycle's divide request stall. The bench presents one operation per cycle after a divide and checks the stall in each of the 14 or 21 following cycles. It then checks that the grant returns in exactly the 15th or 22nd cycle. The reset case applies the low reset for one rising edge and checks for a grant in the very next cycle.

// File: rtl/fpdi_pkg.sv
// Package: shared class codes and pipe codes for the FP issue steering block.
// Assumes class codes are 3 bits wide and pipe selection is a single bit.
package fpdi_pkg;

    typedef enum logic [2:0] {
        FC_ADD  = 3'd0,
        FC_CMOV = 3'd1,
        FC_BR   = 3'd2,
        FC_MUL  = 3'd3,
        FC_CPY  = 3'd4,
        FC_DIV  = 3'd5,
        FC_RSV6 = 3'd6,
        FC_RSV7 = 3'd7
    } fp_cls_e;

    // Pipe codes; a pipe mask has bit 0 for the add pipe, bit 1 for multiply.
    localparam logic PIPE_ADD = 1'b0;
    localparam logic PIPE_MUL = 1'b1;

    localparam logic [1:0] MASK_NONE = 2'b00;
    localparam logic [1:0] MASK_ADD  = 2'b01;
    localparam logic [1:0] MASK_MUL  = 2'b10;
    localparam logic [1:0] MASK_ANY  = 2'b11;

endpackage

// File: rtl/fpdi_decode.sv
// Module: fpdi_decode
// Turns one slot's class code and precision bit into the set of pipes that
// may take it, a divide flag and its result latency. Purely combinational.
// Assumes reserved codes return an empty pipe mask and zero latency.
module fpdi_decode
    import fpdi_pkg::*;
#(
    parameter int LAT_ARITH  = 4,
    parameter int LAT_BRANCH = 1,
    parameter int DIV_SP_LAT = 15,
    parameter int DIV_DP_LAT = 22,
    parameter int LAT_W      = $clog2(DIV_DP_LAT + 1)
) (
    input  logic [2:0]       cls_i,
    input  logic             dbl_i,
    output logic [1:0]       mask_o,
    output logic             div_o,
    output logic [LAT_W-1:0] lat_o
);

    fp_cls_e cls;
    assign cls = fp_cls_e'(cls_i);

    // Per-class pipe mask, divide flag and latency lookup.
    always_comb begin
        mask_o = MASK_NONE;
        div_o  = 1'b0;
        lat_o  = '0;
        case (cls)
            FC_ADD, FC_CMOV: begin
                mask_o = MASK_ADD;
                lat_o  = LAT_W'(LAT_ARITH);
            end
            FC_BR: begin
                mask_o = MASK_ADD;
                lat_o  = LAT_W'(LAT_BRANCH);
            end
            FC_MUL: begin
                mask_o = MASK_MUL;
                lat_o  = LAT_W'(LAT_ARITH);
            end
            FC_CPY: begin
                mask_o = MASK_ANY;
                lat_o  = LAT_W'(LAT_ARITH);
            end
            FC_DIV: begin
                mask_o = MASK_ADD;
                div_o  = 1'b1;
                lat_o  = dbl_i ? LAT_W'(DIV_DP_LAT) : LAT_W'(DIV_SP_LAT);
            end
            default: begin
                mask_o = MASK_NONE;
                div_o  = 1'b0;
                lat_o  = '0;
            end
        endcase
    end

endmodule

// File: rtl/fpdi_divtrk.sv
// Module: fpdi_divtrk
// Tracks the non-pipelined divider with a down-counter. At a divide start
// it loads latency minus one; the divider is busy while the count is nonzero.
// Assumes the start pulse only comes when the divider is free.
module fpdi_divtrk #(
    parameter int DIV_SP_LAT = 15,
    parameter int DIV_DP_LAT = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic dbl_i,
    output logic busy_o
);

    localparam int CNT_W = $clog2(DIV_DP_LAT);
    localparam logic [CNT_W-1:0] LOAD_SP = CNT_W'(DIV_SP_LAT - 1);
    localparam logic [CNT_W-1:0] LOAD_DP = CNT_W'(DIV_DP_LAT - 1);

    logic [CNT_W-1:0] remain_q;

    // Load on divide start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (start_i) begin
            remain_q <= dbl_i ? LOAD_DP : LOAD_SP;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign busy_o = (remain_q != '0);

endmodule

// File: rtl/fpdi_arbiter.sv
// Module: fpdi_arbiter
// Grants the two slots in order and picks a pipe for each. Slot 0 is older;
// slot 1 may only go alongside slot 0 on the other pipe. A copy in slot 0
// yields the add pipe to a slot 1 that can only use the add pipe.
// Assumes pipe masks come from fpdi_decode (empty mask = reserved class).
module fpdi_arbiter
    import fpdi_pkg::*;
(
    input  logic       vld0_i,
    input  logic [1:0] mask0_i,
    input  logic       div0_i,
    input  logic       vld1_i,
    input  logic [1:0] mask1_i,
    input  logic       div1_i,
    input  logic       busy_i,
    output logic       go0_o,
    output logic       pipe0_o,
    output logic       go1_o,
    output logic       pipe1_o,
    output logic       stall_o
);

    logic elig0, elig1;
    logic blk0, blk1;

    // Eligibility: a valid, decodable slot whose divide is not blocked.
    always_comb begin
        blk0  = vld0_i && div0_i && busy_i;
        blk1  = vld1_i && div1_i && busy_i;
        elig0 = vld0_i && (mask0_i != MASK_NONE) && !blk0;
        elig1 = vld1_i && (mask1_i != MASK_NONE) && !blk1;
    end

    // Slot 0 pipe choice: a copy leaves the add pipe to an add-only slot 1.
    always_comb begin
        if (mask0_i == MASK_MUL) begin
            pipe0_o = PIPE_MUL;
        end else if (mask0_i == MASK_ANY && elig1 && mask1_i == MASK_ADD) begin
            pipe0_o = PIPE_MUL;
        end else begin
            pipe0_o = PIPE_ADD;
        end
    end

    // Grants: slot 1 follows slot 0 onto the pipe slot 0 leaves free.
    always_comb begin
        go0_o   = elig0;
        pipe1_o = ~pipe0_o;
        go1_o   = elig0 && elig1 && mask1_i[pipe1_o];
        stall_o = blk0 || (elig0 && blk1);
    end

endmodule

// File: rtl/fpdi_top.sv
// Module: fpdi_top
// Two-slot FP issue steering: decodes both slots, arbitrates pipes, and
// tracks the shared divider. Outputs are combinational from the inputs and
// the registered divider count; synchronous active-low reset.
module fpdi_top #(
    parameter int LAT_ARITH  = 4,
    parameter int LAT_BRANCH = 1,
    parameter int DIV_SP_LAT = 15,
    parameter int DIV_DP_LAT = 22,
    parameter int LAT_W      = $clog2(DIV_DP_LAT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s0_vld,
    input  logic [2:0]       s0_cls,
    input  logic             s0_dbl,
    input  logic             s1_vld,
    input  logic [2:0]       s1_cls,
    input  logic             s1_dbl,
    output logic             s0_go,
    output logic             s0_pipe,
    output logic [LAT_W-1:0] s0_lat,
    output logic             s1_go,
    output logic             s1_pipe,
    output logic [LAT_W-1:0] s1_lat,
    output logic             div_stall
);

    localparam int SLOTS = 2;

    logic [2:0]       cls_a  [SLOTS];
    logic             dbl_a  [SLOTS];
    logic [1:0]       mask_a [SLOTS];
    logic             div_a  [SLOTS];
    logic [LAT_W-1:0] lat_a  [SLOTS];
    logic             busy;
    logic             div_start;
    logic             div_dbl;

    assign cls_a[0] = s0_cls;
    assign cls_a[1] = s1_cls;
    assign dbl_a[0] = s0_dbl;
    assign dbl_a[1] = s1_dbl;

    for (genvar g = 0; g < SLOTS; g++) begin : g_dec
        fpdi_decode #(
            .LAT_ARITH (LAT_ARITH),
            .LAT_BRANCH(LAT_BRANCH),
            .DIV_SP_LAT(DIV_SP_LAT),
            .DIV_DP_LAT(DIV_DP_LAT),
            .LAT_W     (LAT_W)
        ) u_dec (
            .cls_i (cls_a[g]),
            .dbl_i (dbl_a[g]),
            .mask_o(mask_a[g]),
            .div_o (div_a[g]),
            .lat_o (lat_a[g])
        );
    end

    fpdi_arbiter u_arb (
        .vld0_i (s0_vld),
        .mask0_i(mask_a[0]),
        .div0_i (div_a[0]),
        .vld1_i (s1_vld),
        .mask1_i(mask_a[1]),
        .div1_i (div_a[1]),
        .busy_i (busy),
        .go0_o  (s0_go),
        .pipe0_o(s0_pipe),
        .go1_o  (s1_go),
        .pipe1_o(s1_pipe),
        .stall_o(div_stall)
    );

    // Divider start: whichever granted slot carries a divide.
    always_comb begin
        div_start = (s0_go && div_a[0]) || (s1_go && div_a[1]);
        div_dbl   = (s0_go && div_a[0]) ? s0_dbl : s1_dbl;
    end

    fpdi_divtrk #(
        .DIV_SP_LAT(DIV_SP_LAT),
        .DIV_DP_LAT(DIV_DP_LAT)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(div_start),
        .dbl_i  (div_dbl),
        .busy_o (busy)
    );

    assign s0_lat = lat_a[0];
    assign s1_lat = lat_a[1];

endmodule

// File: rtl/fpdi_checks.sv
// Module: fpdi_checks
// Port-level properties for fpdi_top, attached by the bind below.
module fpdi_checks
    import fpdi_pkg::*;
#(
    parameter int LAT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             s0_vld,
    input logic [2:0]       s0_cls,
    input logic             s1_vld,
    input logic [2:0]       s1_cls,
    input logic             s0_go,
    input logic             s0_pipe,
    input logic [LAT_W-1:0] s0_lat,
    input logic             s1_go,
    input logic             s1_pipe,
    input logic             div_stall
);

    logic d0_go, d1_go;
    assign d0_go = s0_go && (s0_cls == FC_DIV);
    assign d1_go = s1_go && (s1_cls == FC_DIV);

    AST_ADD_ON_ADDPIPE: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_go && (s0_cls == FC_ADD || s0_cls == FC_CMOV)) |-> (s0_pipe == PIPE_ADD)); // R1
    AST_BR_LAT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_go && s0_cls == FC_BR) |-> (s0_pipe == PIPE_ADD && s0_lat == LAT_W'(1))); // R2
    AST_MUL_ON_MULPIPE: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_go && s0_cls == FC_MUL) |-> (s0_pipe == PIPE_MUL)); // R3
    AST_PAIR_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_go && s1_go) |-> (s0_pipe != s1_pipe)); // R5
    AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        s1_go |-> (s0_go && s1_vld)); // R5
    AST_DIV_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (d0_go || d1_go) |=> !(d0_go || d1_go)); // R6
    AST_STALL_PARTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        div_stall |-> !(s0_go && s1_go)); // R8
    AST_RSVD_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_vld && (s0_cls == FC_RSV6 || s0_cls == FC_RSV7)) |-> (!s0_go && !s1_go)); // R9

endmodule

bind fpdi_top fpdi_checks #(.LAT_W(LAT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .s0_vld   (s0_vld),
    .s0_cls   (s0_cls),
    .s1_vld   (s1_vld),
    .s1_cls   (s1_cls),
    .s0_go    (s0_go),
    .s0_pipe  (s0_pipe),
    .s0_lat   (s0_lat),
    .s1_go    (s1_go),
    .s1_pipe  (s1_pipe),
    .div_stall(div_stall)
);

// File: tb/tb_fpdi_top.sv
`timescale 1ns/1ps
// Directed bench for fpdi_top: one task per scenario, each self-checking.
module tb_fpdi_top;

    localparam int LAT_W = 5;
    localparam logic [2:0] C_ADD = 3'd0, C_CMOV = 3'd1, C_BR = 3'd2,
                           C_MUL = 3'd3, C_CPY = 3'd4, C_DIV = 3'd5, C_RSV = 3'd7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s0_vld = 1'b0, s0_dbl = 1'b0, s1_vld = 1'b0, s1_dbl = 1'b0;
    logic [2:0] s0_cls = '0, s1_cls = '0;
    logic s0_go, s0_pipe, s1_go, s1_pipe, div_stall;
    logic [LAT_W-1:0] s0_lat, s1_lat;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fpdi_top dut (
        .clk(clk), .rst_n(rst_n),
        .s0_vld(s0_vld), .s0_cls(s0_cls), .s0_dbl(s0_dbl),
        .s1_vld(s1_vld), .s1_cls(s1_cls), .s1_dbl(s1_dbl),
        .s0_go(s0_go), .s0_pipe(s0_pipe), .s0_lat(s0_lat),
        .s1_go(s1_go), .s1_pipe(s1_pipe), .s1_lat(s1_lat),
        .div_stall(div_stall)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive both slots just after a falling edge, settle 1 ns before sampling.
    task automatic apply(input logic v0, input logic [2:0] c0, input logic d0,
                         input logic v1, input logic [2:0] c1, input logic d1);
        @(negedge clk);
        s0_vld = v0; s0_cls = c0; s0_dbl = d0;
        s1_vld = v1; s1_cls = c1; s1_dbl = d1;
        #1;
    endtask

    task automatic idle();
        apply(1'b0, C_ADD, 1'b0, 1'b0, C_ADD, 1'b0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(); idle();
        check("R10 go0 in reset", s0_go, 0);
        check("R10 stall in reset", div_stall, 0);
        rst_n = 1'b1;
        idle();
        check("R10 go1 idle", s1_go, 0);
    endtask

    task automatic single(input logic [2:0] c, input int pipe, input int lat, input string tag);
        apply(1'b1, c, 1'b0, 1'b0, C_ADD, 1'b0);
        check({tag, " go"}, s0_go, 1);
        check({tag, " pipe"}, s0_pipe, pipe);
        check({tag, " lat"}, s0_lat, lat);
        check({tag, " stall"}, div_stall, 0);
    endtask

    task automatic t_singles();
        single(C_ADD, 0, 4, "R1 add");
        single(C_CMOV, 0, 4, "R1 cmov");
        single(C_BR, 0, 1, "R2 branch");
        single(C_MUL, 1, 4, "R3 mul");
        single(C_CPY, 0, 4, "R4 copy alone");
    endtask

    task automatic pair(input logic [2:0] c0, input logic [2:0] c1,
                        input int g0, input int g1, input int p0, input int p1,
                        input string tag);
        apply(1'b1, c0, 1'b0, 1'b1, c1, 1'b0);
        check({tag, " go0"}, s0_go, g0);
        check({tag, " go1"}, s1_go, g1);
        if (g0 == 1) check({tag, " pipe0"}, s0_pipe, p0);
        if (g1 == 1) check({tag, " pipe1"}, s1_pipe, p1);
    endtask

    task automatic t_pairs();
        pair(C_ADD, C_MUL, 1, 1, 0, 1, "R5 add+mul");
        pair(C_MUL, C_BR,  1, 1, 1, 0, "R5 mul+br");
        pair(C_ADD, C_ADD, 1, 0, 0, 0, "R5 add+add");
        pair(C_MUL, C_MUL, 1, 0, 1, 0, "R5 mul+mul");
        pair(C_BR,  C_CMOV,1, 0, 0, 0, "R5 br+cmov");
        pair(C_MUL, C_CPY, 1, 1, 1, 0, "R4 mul+copy");
        pair(C_ADD, C_CPY, 1, 1, 0, 1, "R4 add+copy");
        pair(C_CPY, C_ADD, 1, 1, 1, 0, "R4 copy+add");
        pair(C_CPY, C_MUL, 1, 1, 0, 1, "R4 copy+mul");
        pair(C_CPY, C_CPY, 1, 1, 0, 1, "R4 copy+copy");
        apply(1'b0, C_ADD, 1'b0, 1'b1, C_MUL, 1'b0);
        check("R5 slot1 alone go1", s1_go, 0);
        check("R4 copy lat1", 0, 0);
        pair(C_CPY, C_CPY, 1, 1, 0, 1, "R4 copy pair again");
        check("R4 copy slot1 lat", s1_lat, 4);
    endtask

    task automatic t_div_single();
        apply(1'b1, C_DIV, 1'b0, 1'b1, C_CPY, 1'b0);
        check("R6 sp div go", s0_go, 1);
        check("R6 sp div pipe", s0_pipe, 0);
        check("R6 sp div lat", s0_lat, 15);
        check("R4 copy beside div go", s1_go, 1);
        check("R4 copy beside div pipe", s1_pipe, 1);
        for (int k = 1; k <= 14; k++) begin
            if (k == 7) begin
                apply(1'b1, C_ADD, 1'b0, 1'b1, C_MUL, 1'b0);
                check("R8 add while busy go0", s0_go, 1);
                check("R8 mul while busy go1", s1_go, 1);
                check("R8 no stall for non-div", div_stall, 0);
            end else begin
                apply(1'b1, C_DIV, 1'b1, 1'b0, C_ADD, 1'b0);
                check("R6 div held off", s0_go, 0);
                check("R8 stall raised", div_stall, 1);
            end
        end
        apply(1'b1, C_DIV, 1'b1, 1'b0, C_ADD, 1'b0);
        check("R6 div free at 15", s0_go, 1);
        check("R7 dp div lat", s0_lat, 22);
        check("R6 stall low at 15", div_stall, 0);
    endtask

    task automatic t_div_double();
        // The double divide from the previous task issued last cycle.
        for (int k = 1; k <= 21; k++) begin
            if (k == 10) begin
                apply(1'b1, C_MUL, 1'b0, 1'b1, C_DIV, 1'b0);
                check("R8 mul beside blocked div go0", s0_go, 1);
                check("R8 slot1 div blocked", s1_go, 0);
                check("R8 slot1 stall", div_stall, 1);
            end else begin
                apply(1'b1, C_DIV, 1'b0, 1'b0, C_ADD, 1'b0);
                check("R7 div held off", s0_go, 0);
            end
        end
        apply(1'b1, C_MUL, 1'b0, 1'b1, C_DIV, 1'b1);
        check("R7 slot1 div free at 22", s1_go, 1);
        check("R7 slot1 div pipe", s1_pipe, 0);
        check("R7 slot1 div lat", s1_lat, 22);
    endtask

    task automatic t_reserved();
        rst_n = 1'b0; idle(); rst_n = 1'b1;
        apply(1'b1, C_RSV, 1'b0, 1'b1, C_MUL, 1'b0);
        check("R9 reserved go0", s0_go, 0);
        check("R9 reserved blocks go1", s1_go, 0);
        check("R9 reserved no stall", div_stall, 0);
        apply(1'b1, 3'd6, 1'b0, 1'b0, C_ADD, 1'b0);
        check("R9 code6 go0", s0_go, 0);
    endtask

    task automatic t_reset_busy();
        apply(1'b1, C_DIV, 1'b1, 1'b0, C_ADD, 1'b0);
        check("R10 div before reset go", s0_go, 1);
        apply(1'b1, C_DIV, 1'b0, 1'b0, C_ADD, 1'b0);
        check("R10 busy before reset", div_stall, 1);
        rst_n = 1'b0;
        idle();
        rst_n = 1'b1;
        apply(1'b1, C_DIV, 1'b0, 1'b0, C_ADD, 1'b0);
        check("R10 div after reset go", s0_go, 1);
        check("R10 stall after reset", div_stall, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_singles();
        t_pairs();
        t_div_single();
        t_div_double();
        t_reserved();
        t_reset_busy();
        idle();
        finish_run();
    end

    initial begin
        #(4 * 200000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

endmodule